// File: doc/BRIEF.md
# Graphics DMA Configuration Checker

This block sits in front of a 2D pixel-transfer engine. It judges the programmed setup in the cycle a start request arrives. The setup covers the transfer mode, the addresses and colour formats of each layer, the line offsets, the transfer dimensions and any automatic palette loads. The block then either lets the start through or refuses it. The judgement is purely combinational over the configuration inputs. The outcome is registered, so exactly one of two one-cycle pulses follows each start: accepted or refused.

A refused start also sets a sticky error flag, and the flag stays set until software clears it through a write-one-to-clear input. Which rules apply depends on the mode. The foreground source is ignored when the engine fills from a register value. The background is only read when blending. The output format only matters when the engine converts pixels.

Top module: `gfx_cfg_check`

## Requirements
- R1: A start with a line count of 0 or a pixels-per-line count of 0 is refused in every mode.
- R2: Mode encoding is 0 plain copy, 1 copy with conversion, 2 blend and 3 register fill. In modes 0, 1 and 2, a start is refused when the foreground format code is above 10. It is also refused when the foreground address is misaligned: codes 0 need addr[1:0]=0, codes 2, 3, 4 and 7 need addr[0]=0, and all other codes need byte alignment only. In mode 3 the foreground inputs have no effect.
- R3: In modes 0, 1 and 2, a foreground format code of 8 or 10 (4 bits per pixel) with an odd pixels-per-line count or an odd foreground line offset is refused.
- R4: Only in mode 2, the background obeys the same format-legality, alignment and 4-bit odd-count/odd-offset rules as the foreground. In other modes the background inputs have no effect.
- R5: In modes 1, 2 and 3, a start is refused when the output format code is above 4. It is also refused when the output address is misaligned: code 0 needs addr[1:0]=0, codes 2 to 4 need addr[0]=0, and code 1 needs byte alignment. In mode 0 the output inputs have no effect.
- R6: When a foreground or background palette load is requested, a palette format bit of 0 (32-bit entries) needs addr[1:0]=0, and a bit of 1 (24-bit entries) needs byte alignment. Without a load request, the palette inputs have no effect.
- R7: For a start in cycle N, exactly one of start_ok_o and cfg_err_pulse_o is high in cycle N+1, for one cycle. Neither is high without a start.
- R8: A refused start sets cfg_err_flag_o. The flag stays set until err_clr_i is high, and a refusal in the same cycle as a clear keeps it set.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| mode_i | input | 2 | Transfer mode (0 copy, 1 convert, 2 blend, 3 fill) |
| fg_addr_i | input | 32 | Foreground start address |
| fg_cm_i | input | 4 | Foreground format code |
| fg_off_i | input | 14 | Foreground line offset in pixels |
| bg_addr_i | input | 32 | Background start address |
| bg_cm_i | input | 4 | Background format code |
| bg_off_i | input | 14 | Background line offset in pixels |
| out_addr_i | input | 32 | Output start address |
| out_cm_i | input | 4 | Output format code |
| ppl_i | input | 14 | Pixels per line |
| nl_i | input | 16 | Number of lines |
| fg_pal_ld_i | input | 1 | Foreground palette load requested |
| fg_pal_addr_i | input | 32 | Foreground palette address |
| fg_pal_cm_i | input | 1 | Foreground palette format (0 32-bit, 1 24-bit) |
| bg_pal_ld_i | input | 1 | Background palette load requested |
| bg_pal_addr_i | input | 32 | Background palette address |
| bg_pal_cm_i | input | 1 | Background palette format (0 32-bit, 1 24-bit) |
| start_ok_o | output | 1 | Start accepted pulse |
| cfg_err_pulse_o | output | 1 | Start refused pulse |
| cfg_err_flag_o | output | 1 | Sticky configuration error flag |

## Verification
The bench pairs bad settings with the modes that must ignore them. Examples are an illegal foreground code in fill mode, a broken background outside blend mode, and a bad output format in plain copy. A design that applied a rule in every mode would refuse these starts. It also drives odd pixel counts and offsets against 4-bit and 8-bit formats, where a design that tested oddness for every format would refuse legal transfers. It checks misaligned 24-bit addresses, which a design treating 24-bit as word-sized would reject. On the flag, it checks the hold without a clear and the case where a set and a clear land in the same cycle, which a design with clear priority would lose.

// File: rtl/gfx_cfg_pkg.sv
package gfx_cfg_pkg;

  localparam int unsigned CM_W = 4;
  localparam logic [CM_W-1:0] IN_CM_LAST  = 4'd10;
  localparam logic [CM_W-1:0] OUT_CM_LAST = 4'd4;

  typedef enum logic [1:0] {
    XM_COPY  = 2'd0,
    XM_CONV  = 2'd1,
    XM_BLEND = 2'd2,
    XM_FILL  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    AL_BYTE = 2'd0,
    AL_HALF = 2'd1,
    AL_WORD = 2'd2
  } align_e;

  function automatic align_e in_align(logic [CM_W-1:0] cm);
    case (cm)
      4'd0:                   return AL_WORD;
      4'd2, 4'd3, 4'd4, 4'd7: return AL_HALF;
      default:                return AL_BYTE;
    endcase
  endfunction

  function automatic align_e out_align(logic [CM_W-1:0] cm);
    case (cm)
      4'd0:             return AL_WORD;
      4'd2, 4'd3, 4'd4: return AL_HALF;
      default:          return AL_BYTE;
    endcase
  endfunction

  function automatic logic is_nibble(logic [CM_W-1:0] cm);
    return (cm == 4'd8) || (cm == 4'd10);
  endfunction

  function automatic logic misaligned(align_e a, logic [1:0] lo);
    case (a)
      AL_WORD: return |lo;
      AL_HALF: return lo[0];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gfx_layer_chk.sv
module gfx_layer_chk
  import gfx_cfg_pkg::*;
#(
  parameter int unsigned OFW = 14,
  parameter int unsigned PW  = 14
) (
  input  logic            en_i,
  input  logic [1:0]      addr_lo_i,
  input  logic [CM_W-1:0] cm_i,
  input  logic [OFW-1:0]  off_i,
  input  logic [PW-1:0]   ppl_i,
  output logic            err_o
);

  logic cm_bad, algn_bad, odd_bad;

  always_comb begin
    cm_bad   = cm_i > IN_CM_LAST;
    algn_bad = misaligned(in_align(cm_i), addr_lo_i);
    odd_bad  = is_nibble(cm_i) && (ppl_i[0] || off_i[0]);
    err_o    = en_i && (cm_bad || algn_bad || odd_bad);
  end

  // R3 R4
  always_comb begin
    if (en_i && is_nibble(cm_i) && ppl_i[0]) begin
      odd_ppl_chk: assert (err_o);
    end
  end

  logic [OFW-2:0] unused_off;
  logic [PW-2:0]  unused_ppl;
  assign unused_off = off_i[OFW-1:1];
  assign unused_ppl = ppl_i[PW-1:1];

endmodule

// File: rtl/gfx_out_chk.sv
module gfx_out_chk
  import gfx_cfg_pkg::*;
(
  input  logic            en_i,
  input  logic [1:0]      addr_lo_i,
  input  logic [CM_W-1:0] cm_i,
  output logic            err_o
);

  always_comb begin
    err_o = en_i && ((cm_i > OUT_CM_LAST) ||
                     misaligned(out_align(cm_i), addr_lo_i));
  end

  // R5
  always_comb begin
    if (en_i && cm_i > OUT_CM_LAST) begin
      out_cm_chk: assert (err_o);
    end
  end

endmodule

// File: rtl/gfx_pal_chk.sv
module gfx_pal_chk (
  input  logic       ld_i,
  input  logic [1:0] addr_lo_i,
  input  logic       cm_i,
  output logic       err_o
);

  // cm_i 0: 32-bit entries, word aligned; 1: 24-bit entries, byte aligned
  assign err_o = ld_i && !cm_i && (|addr_lo_i);

  // R6
  always_comb begin
    if (!ld_i) begin
      pal_idle_chk: assert (!err_o);
    end
  end

endmodule

// File: rtl/gfx_cfg_check.sv
module gfx_cfg_check
  import gfx_cfg_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned OFW = 14,
  parameter int unsigned PW  = 14,
  parameter int unsigned LW  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            err_clr_i,
  input  logic [1:0]      mode_i,
  input  logic [AW-1:0]   fg_addr_i,
  input  logic [CM_W-1:0] fg_cm_i,
  input  logic [OFW-1:0]  fg_off_i,
  input  logic [AW-1:0]   bg_addr_i,
  input  logic [CM_W-1:0] bg_cm_i,
  input  logic [OFW-1:0]  bg_off_i,
  input  logic [AW-1:0]   out_addr_i,
  input  logic [CM_W-1:0] out_cm_i,
  input  logic [PW-1:0]   ppl_i,
  input  logic [LW-1:0]   nl_i,
  input  logic            fg_pal_ld_i,
  input  logic [AW-1:0]   fg_pal_addr_i,
  input  logic            fg_pal_cm_i,
  input  logic            bg_pal_ld_i,
  input  logic [AW-1:0]   bg_pal_addr_i,
  input  logic            bg_pal_cm_i,
  output logic            start_ok_o,
  output logic            cfg_err_pulse_o,
  output logic            cfg_err_flag_o
);

  localparam int unsigned NLAY = 2;

  xfer_mode_e mode;
  assign mode = xfer_mode_e'(mode_i);

  logic            lay_en   [NLAY];
  logic [1:0]      lay_alo  [NLAY];
  logic [CM_W-1:0] lay_cm   [NLAY];
  logic [OFW-1:0]  lay_off  [NLAY];
  logic            lay_err  [NLAY];
  logic            pal_ld   [NLAY];
  logic [1:0]      pal_alo  [NLAY];
  logic            pal_cm   [NLAY];
  logic            pal_err  [NLAY];

  assign lay_en[0]  = mode != XM_FILL;
  assign lay_en[1]  = mode == XM_BLEND;
  assign lay_alo[0] = fg_addr_i[1:0];
  assign lay_alo[1] = bg_addr_i[1:0];
  assign lay_cm[0]  = fg_cm_i;
  assign lay_cm[1]  = bg_cm_i;
  assign lay_off[0] = fg_off_i;
  assign lay_off[1] = bg_off_i;
  assign pal_ld[0]  = fg_pal_ld_i;
  assign pal_ld[1]  = bg_pal_ld_i;
  assign pal_alo[0] = fg_pal_addr_i[1:0];
  assign pal_alo[1] = bg_pal_addr_i[1:0];
  assign pal_cm[0]  = fg_pal_cm_i;
  assign pal_cm[1]  = bg_pal_cm_i;

  for (genvar g = 0; g < NLAY; g++) begin : g_lay
    gfx_layer_chk #(.OFW(OFW), .PW(PW)) u_lay (
      .en_i     (lay_en[g]),
      .addr_lo_i(lay_alo[g]),
      .cm_i     (lay_cm[g]),
      .off_i    (lay_off[g]),
      .ppl_i    (ppl_i),
      .err_o    (lay_err[g])
    );
    gfx_pal_chk u_pal (
      .ld_i     (pal_ld[g]),
      .addr_lo_i(pal_alo[g]),
      .cm_i     (pal_cm[g]),
      .err_o    (pal_err[g])
    );
  end

  logic out_err;
  gfx_out_chk u_out (
    .en_i     (mode != XM_COPY),
    .addr_lo_i(out_addr_i[1:0]),
    .cm_i     (out_cm_i),
    .err_o    (out_err)
  );

  logic dim_err, cfg_bad;
  assign dim_err = (nl_i == '0) || (ppl_i == '0);
  assign cfg_bad = dim_err || out_err || lay_err[0] || lay_err[1] ||
                   pal_err[0] || pal_err[1];

  logic ok_q, errp_q, flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q    <= 1'b0;
      errp_q  <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      ok_q    <= start_i && !cfg_bad;
      errp_q  <= start_i && cfg_bad;
      if (start_i && cfg_bad) flag_q <= 1'b1;   // set wins over clear
      else if (err_clr_i)     flag_q <= 1'b0;
    end
  end

  assign start_ok_o      = ok_q;
  assign cfg_err_pulse_o = errp_q;
  assign cfg_err_flag_o  = flag_q;

  logic unused_addr;
  assign unused_addr = ^{fg_addr_i[AW-1:2], bg_addr_i[AW-1:2], out_addr_i[AW-1:2],
                         fg_pal_addr_i[AW-1:2], bg_pal_addr_i[AW-1:2]};

  // R7
  ok_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok_o |-> $past(start_i));

  // R7
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(start_i)) |-> (start_ok_o ^ cfg_err_pulse_o));

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_flag_o && !err_clr_i) |=> cfg_err_flag_o);

  // R8
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_flag_o) |-> cfg_err_pulse_o);

  // R1
  dim_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (nl_i == '0 || ppl_i == '0)) |=> cfg_err_pulse_o);

endmodule

// File: tb/gfx_cfg_check_bench.sv
module gfx_cfg_check_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, err_clr_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] fg_addr_i = '0, bg_addr_i = '0, out_addr_i = '0;
  logic [31:0] fg_pal_addr_i = '0, bg_pal_addr_i = '0;
  logic [3:0]  fg_cm_i = '0, bg_cm_i = '0, out_cm_i = '0;
  logic [13:0] fg_off_i = '0, bg_off_i = '0, ppl_i = 14'd4;
  logic [15:0] nl_i = 16'd2;
  logic        fg_pal_ld_i = 1'b0, fg_pal_cm_i = 1'b0;
  logic        bg_pal_ld_i = 1'b0, bg_pal_cm_i = 1'b0;
  logic        start_ok_o, cfg_err_pulse_o, cfg_err_flag_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  gfx_cfg_check u_gfx_cfg_check (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  fgc;  logic [1:0] fga;
    logic [3:0]  bgc;  logic [1:0] bga;
    logic [3:0]  oc;   logic [1:0] oa;
    logic [13:0] fgo;  logic [13:0] bgo;
    logic [13:0] ppl;  logic [15:0] nl;
    logic        fpl;  logic [1:0] fpa; logic fpc;
    logic        bpl;  logic [1:0] bpa; logic bpc;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{0, 0,0,  0,0,  0,0, 0,0, 4,2, 0,0,0, 0,0,0, 0, 7},  // R7 legal copy
    '{0, 0,0,  0,0,  0,0, 0,0, 4,0, 0,0,0, 0,0,0, 1, 1},  // R1 nl=0
    '{3, 0,0,  0,0,  0,0, 0,0, 0,2, 0,0,0, 0,0,0, 1, 1},  // R1 ppl=0 fill
    '{0, 11,0, 0,0,  0,0, 0,0, 4,2, 0,0,0, 0,0,0, 1, 2},  // R2 bad fg code
    '{3, 11,1, 0,0,  0,0, 0,0, 4,2, 0,0,0, 0,0,0, 0, 2},  // R2 fill ignores fg
    '{1, 2,1,  0,0,  0,0, 0,0, 4,2, 0,0,0, 0,0,0, 1, 2},  // R2 16-bit odd addr
    '{1, 1,3,  0,0,  0,0, 0,0, 4,2, 0,0,0, 0,0,0, 0, 2},  // R2 24-bit byte ok
    '{0, 8,0,  0,0,  0,0, 0,0, 5,2, 0,0,0, 0,0,0, 1, 3},  // R3 4bpp odd ppl
    '{0, 10,0, 0,0,  0,0, 3,0, 4,2, 0,0,0, 0,0,0, 1, 3},  // R3 4bpp odd offset
    '{0, 5,0,  0,0,  0,0, 3,0, 5,2, 0,0,0, 0,0,0, 0, 3},  // R3 8bpp odd ok
    '{1, 0,0,  15,1, 0,0, 0,0, 4,2, 0,0,0, 0,0,0, 0, 4},  // R4 bg ignored
    '{2, 0,0,  15,0, 0,0, 0,0, 4,2, 0,0,0, 0,0,0, 1, 4},  // R4 bad bg code
    '{2, 0,0,  0,2,  0,0, 0,0, 4,2, 0,0,0, 0,0,0, 1, 4},  // R4 bg word misalign
    '{2, 0,0,  8,0,  0,0, 0,1, 4,2, 0,0,0, 0,0,0, 1, 4},  // R4 bg 4bpp odd offset
    '{0, 0,0,  0,0,  7,1, 0,0, 4,2, 0,0,0, 0,0,0, 0, 5},  // R5 copy ignores out
    '{1, 0,0,  0,0,  5,0, 0,0, 4,2, 0,0,0, 0,0,0, 1, 5},  // R5 bad out code
    '{3, 0,0,  0,0,  2,1, 0,0, 4,2, 0,0,0, 0,0,0, 1, 5},  // R5 out half misalign
    '{3, 0,0,  0,0,  1,3, 0,0, 4,2, 0,0,0, 0,0,0, 0, 5},  // R5 out 24-bit ok
    '{0, 0,0,  0,0,  0,0, 0,0, 4,2, 1,2,0, 0,0,0, 1, 6},  // R6 fg pal misalign
    '{0, 0,0,  0,0,  0,0, 0,0, 4,2, 1,3,1, 0,0,0, 0, 6},  // R6 24-bit pal ok
    '{0, 0,0,  0,0,  0,0, 0,0, 4,2, 0,1,0, 0,0,0, 0, 6},  // R6 no load ignored
    '{0, 0,0,  0,0,  0,0, 0,0, 4,2, 0,0,0, 1,1,0, 1, 6}   // R6 bg pal misalign
  };

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    mode_i        = v.mode;
    fg_cm_i       = v.fgc; fg_addr_i  = 32'h2000_0000 | 32'(v.fga);
    bg_cm_i       = v.bgc; bg_addr_i  = 32'h2100_0000 | 32'(v.bga);
    out_cm_i      = v.oc;  out_addr_i = 32'h2200_0000 | 32'(v.oa);
    fg_off_i      = v.fgo; bg_off_i   = v.bgo;
    ppl_i         = v.ppl; nl_i       = v.nl;
    fg_pal_ld_i   = v.fpl; fg_pal_addr_i = 32'h2300_0000 | 32'(v.fpa); fg_pal_cm_i = v.fpc;
    bg_pal_ld_i   = v.bpl; bg_pal_addr_i = 32'h2400_0000 | 32'(v.bpa); bg_pal_cm_i = v.bpc;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic clear_flag();
    err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9", "ok in reset", start_ok_o, 1'b0);
    check("R9", "err pulse in reset", cfg_err_pulse_o, 1'b0);
    check("R9", "flag in reset", cfg_err_flag_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", VECS[i].req, i);
      apply(VECS[i]);
      pulse_start();
      check(tag, "err pulse", cfg_err_pulse_o, VECS[i].exp_err);
      check(tag, "ok pulse", start_ok_o, !VECS[i].exp_err);
      check(tag, "flag", cfg_err_flag_o, VECS[i].exp_err);
      @(negedge clk_i);
      // R7 single-cycle pulses
      check("R7", "err pulse width", cfg_err_pulse_o, 1'b0);
      check("R7", "ok pulse width", start_ok_o, 1'b0);
      clear_flag();
      check("R8", "flag cleared", cfg_err_flag_o, 1'b0);
    end

    // R7 bad config without start: no pulse
    apply(VECS[1]);
    repeat (3) @(negedge clk_i);
    check("R7", "no start err", cfg_err_pulse_o, 1'b0);
    check("R7", "no start flag", cfg_err_flag_o, 1'b0);

    // R8 flag holds without clear, through a later legal start
    pulse_start();
    repeat (5) @(negedge clk_i);
    check("R8", "flag held", cfg_err_flag_o, 1'b1);
    apply(VECS[0]);
    pulse_start();
    check("R8", "ok while flagged", start_ok_o, 1'b1);
    check("R8", "flag kept on ok", cfg_err_flag_o, 1'b1);
    clear_flag();
    check("R8", "flag cleared", cfg_err_flag_o, 1'b0);

    // R8 refusal and clear in the same cycle: set wins
    apply(VECS[1]);
    @(negedge clk_i); start_i = 1'b1; err_clr_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; err_clr_i = 1'b0;
    check("R8", "set beats clear", cfg_err_flag_o, 1'b1);
    check("R8", "pulse on set+clear", cfg_err_pulse_o, 1'b1);
    clear_flag();
    check("R8", "final clear", cfg_err_flag_o, 1'b0);

    // R1 nl=0 in blend mode with a valid setup otherwise
    apply(VECS[0]); mode_i = 2'd2; nl_i = '0;
    pulse_start();
    check("R1", "blend nl=0", cfg_err_pulse_o, 1'b1);
    clear_flag();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule